// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block groups general-purpose pins into banks of 32 and exposes them through a simple word-addressed register port. Every pin has its own configuration word. That word chooses whether the pin is driven or sensed, and which transitions on the pin count as events.

Driven values are never written directly. Software changes them by writing a one-hot or multi-bit pattern to a "raise" address or a "lower" address, so no read-modify-write is needed. The mask works the same way, through its own raise and lower addresses.

Each bank keeps a sticky event register that software acknowledges by writing ones. Each bank drives its own request line. That line is high whenever an event bit is set and its mask bit is clear. Pin inputs are expected to be synchronous to the clock already.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (output enable low), every driven value is 0, every event bit is 0, every mask bit is 1, every request line is low and every configuration word reads 0x1.
- R2: A write to bank n's raise address (0x40+4n) sets the driven bits where the data has ones; bits where the data has zeros keep their value.
- R3: A write to bank n's lower address (0x60+4n) clears the driven bits where the data has ones; bits where the data has zeros keep their value.
- R4: Bit 0 of a pin's configuration word (at 0x100+4p for global pin p) selects the direction: 1 means input with the output enable low, 0 means output with the output enable high and the pin driving its driven value. Only bits 0 and 4:3 are stored; all other bits read 0.
- R5: Bits 4:3 of the configuration word select the event type: 0 means no detection, 1 means rising edge, 2 means falling edge, 3 means both edges. An event is seen in the clock edge that samples the new pin level, and the event bit reads set from that edge on.
- R6: Event bits are sticky. A write to 0x80+4n clears the event bits where the data has ones. A new event in the same cycle as its clear leaves that bit set.
- R7: A write to 0xA0+4n sets the mask bits where the data has ones. A write to 0xC0+4n clears them. Both addresses read back the mask.
- R8: An event sets its event bit even while the pin is masked, so the event becomes pending once the mask bit is cleared.
- R9: Bank n's request line is high exactly when its event register ANDed with the inverted mask is nonzero. It updates in the same clock edge as the event and mask registers.
- R10: Reading 0xE0+4n returns, per pin, the sensed level for an input pin and the driven value for an output pin.
- R11: 0x00+4n, 0x40+4n and 0x60+4n read the driven values, and 0x20+4n reads the sensed pin levels. Writes to 0x00+4n and 0x20+4n have no effect.
- R12: Read data appears on the clock edge that samples the read strobe. Reads of an unaligned address, of a bank index at or above the bank count, or of a configuration word beyond the last pin return 0. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32*NBANKS | Sensed pin levels, already synchronous |
| pin_out | output | 32*NBANKS | Driven pin values |
| pin_oe | output | 32*NBANKS | Output enables, high for output pins |
| irq | output | NBANKS | Per-bank request lines |

## Verification
The bench builds the block with two banks and a 12-bit address. With these values, bank indexing in the register offsets, 64 configuration words and the cross-bank independence of masks and events are all exercised. Unused bank indices and configuration words past pin 63 are also reachable, so the zero-read rule can be tested. Random mixes of pin toggles, raise and lower writes, configuration changes and acknowledge writes are compared against a bench model. Directed cases cover an acknowledge that lands in the same cycle as a new event, and a masked event that becomes visible on unmasking.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BANK_W    = 32;
  localparam int CTRL_WORD = 'h40;  // configuration words start at byte 0x100
  localparam int DIR_BIT   = 0;
  localparam int TRIG_LSB  = 3;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_ANY  = 2'd3
  } trig_sel_t;

  typedef enum logic [2:0] {
    K_DRIVE = 3'd0,
    K_SENSE = 3'd1,
    K_RAISE = 3'd2,
    K_LOWER = 3'd3,
    K_EVENT = 3'd4,
    K_MSET  = 3'd5,
    K_MCLR  = 3'd6,
    K_LEVEL = 3'd7
  } reg_kind_t;

  typedef struct packed {
    logic      is_input;
    trig_sel_t trig;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word,
  input  logic              dir_bit,
  input  logic [1:0]        trig_bits,
  output pin_cfg_t          cfg [NPINS],
  output logic              hit,
  output logic [31:0]       rd_word
);
  localparam int LAST_WORD = CTRL_WORD + NPINS;

  logic [31:0] widx;
  assign widx = 32'(word);
  assign hit  = (widx >= CTRL_WORD) && (widx < LAST_WORD);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[p] <= '{is_input: 1'b1, trig: TRIG_OFF};
      end else if (wr_en && hit && widx == 32'(CTRL_WORD + p)) begin
        cfg[p] <= '{is_input: dir_bit, trig: trig_sel_t'(trig_bits)};
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (hit && widx == 32'(CTRL_WORD + p)) begin
        rd_word[DIR_BIT]            = cfg[p].is_input;
        rd_word[TRIG_LSB+1:TRIG_LSB] = cfg[p].trig;
      end
    end
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  pin_cfg_t     cfg [W],
  output logic [W-1:0] hits
);
  logic [W-1:0] prev_q;

  // Reset loads the current levels so leaving reset never looks like an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= pins;
    else     prev_q <= pins;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise, fall;
    assign rise = pins[i] & ~prev_q[i];
    assign fall = ~pins[i] & prev_q[i];
    always_comb begin
      case (cfg[i].trig)
        TRIG_RISE: hits[i] = rise;
        TRIG_FALL: hits[i] = fall;
        TRIG_ANY:  hits[i] = rise | fall;
        default:   hits[i] = 1'b0;
      endcase
    end
  end

  // R5: a detection needs a level change between two samples
  a_r5_hit_needs_change: assert property (@(posedge clk) disable iff (rst)
    (hits & ~(pins ^ prev_q)) == '0);
endmodule

// File: rtl/gpio_bank_core.sv
module gpio_bank_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         raise_we,
  input  logic         lower_we,
  input  logic         ack_we,
  input  logic         mset_we,
  input  logic         mclr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hits,
  output logic [W-1:0] drive_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] event_q,
  output logic         irq_q
);
  logic [W-1:0] raise_v, lower_v, ack_v, mset_v, mclr_v;
  logic [W-1:0] drive_n, mask_n, event_n;

  assign raise_v = raise_we ? wdata : '0;
  assign lower_v = lower_we ? wdata : '0;
  assign ack_v   = ack_we   ? wdata : '0;
  assign mset_v  = mset_we  ? wdata : '0;
  assign mclr_v  = mclr_we  ? wdata : '0;

  assign drive_n = (drive_q | raise_v) & ~lower_v;
  assign mask_n  = (mask_q | mset_v) & ~mclr_v;
  assign event_n = (event_q & ~ack_v) | hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
      mask_q  <= '1;
      event_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      drive_q <= drive_n;
      mask_q  <= mask_n;
      event_q <= event_n;
      irq_q   <= |(event_n & ~mask_n);
    end
  end

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (drive_q == '0 && mask_q == '1 && event_q == '0 && !irq_q));

  a_r2_rise_needs_raise: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (drive_q & ~$past(drive_q) & ~$past(raise_v)) == '0);

  a_r3_fall_needs_lower: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (~drive_q & $past(drive_q) & ~$past(lower_v)) == '0);

  a_r7_mask_by_write: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((mask_q ^ $past(mask_q)) & ~($past(mset_v) | $past(mclr_v))) == '0);

  a_r6_ack_needs_write: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (~event_q & $past(event_q) & ~$past(ack_v)) == '0);

  a_r6_new_hit_wins: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($past(hits) & ~event_q) == '0);

  a_r8_set_needs_hit: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (event_q & ~$past(event_q) & ~$past(hits)) == '0);

  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_q == ((event_q & ~mask_q) != '0));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_pkg::*;
#(
  parameter int NBANKS = 2,
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic [NBANKS*BANK_W-1:0] pin_in,
  output logic [NBANKS*BANK_W-1:0] pin_out,
  output logic [NBANKS*BANK_W-1:0] pin_oe,
  output logic [NBANKS-1:0]        irq
);
  localparam int NP     = NBANKS * BANK_W;
  localparam int WORD_W = ADDR_W - 2;

  logic      aligned, bank_area, bank_ok, cfg_hit, mapped;
  logic [2:0] bsel;
  reg_kind_t kind;
  logic [31:0] cfg_rd, rd_mux;

  assign aligned   = (addr[1:0] == 2'b00);
  assign bank_area = (addr[ADDR_W-1:8] == '0);
  assign bsel      = addr[4:2];
  assign kind      = reg_kind_t'(addr[7:5]);
  assign bank_ok   = 32'(bsel) < NBANKS;

  pin_cfg_t cfg [NP];

  gpio_pin_cfg #(.NPINS(NP), .WORD_W(WORD_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en && aligned),
    .word      (addr[ADDR_W-1:2]),
    .dir_bit   (wdata[DIR_BIT]),
    .trig_bits (wdata[TRIG_LSB+1:TRIG_LSB]),
    .cfg       (cfg),
    .hit       (cfg_hit),
    .rd_word   (cfg_rd)
  );

  logic [BANK_W-1:0] drive_w [NBANKS];
  logic [BANK_W-1:0] mask_w  [NBANKS];
  logic [BANK_W-1:0] event_w [NBANKS];
  logic [BANK_W-1:0] sense_w [NBANKS];
  logic [BANK_W-1:0] level_w [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    pin_cfg_t          cfg_b [BANK_W];
    logic [BANK_W-1:0] hits_b;
    logic              sel_b;

    assign sel_b      = wr_en && aligned && bank_area && bsel == 3'(b);
    assign sense_w[b] = pin_in[b*BANK_W +: BANK_W];

    for (genvar i = 0; i < BANK_W; i++) begin : g_pin
      assign cfg_b[i]              = cfg[b*BANK_W+i];
      assign level_w[b][i]         = cfg_b[i].is_input ? sense_w[b][i] : drive_w[b][i];
      assign pin_oe[b*BANK_W+i]    = ~cfg_b[i].is_input;
    end

    gpio_edge_det #(.W(BANK_W)) u_det (
      .clk  (clk),
      .rst  (rst),
      .pins (sense_w[b]),
      .cfg  (cfg_b),
      .hits (hits_b)
    );

    gpio_bank_core #(.W(BANK_W)) u_core (
      .clk      (clk),
      .rst      (rst),
      .raise_we (sel_b && kind == K_RAISE),
      .lower_we (sel_b && kind == K_LOWER),
      .ack_we   (sel_b && kind == K_EVENT),
      .mset_we  (sel_b && kind == K_MSET),
      .mclr_we  (sel_b && kind == K_MCLR),
      .wdata    (wdata),
      .hits     (hits_b),
      .drive_q  (drive_w[b]),
      .mask_q   (mask_w[b]),
      .event_q  (event_w[b]),
      .irq_q    (irq[b])
    );

    assign pin_out[b*BANK_W +: BANK_W] = drive_w[b];
  end

  always_comb begin
    rd_mux = '0;
    mapped = 1'b0;
    if (aligned && bank_area && bank_ok) begin
      mapped = 1'b1;
      for (int b = 0; b < NBANKS; b++) begin
        if (32'(bsel) == b) begin
          case (kind)
            K_DRIVE, K_RAISE, K_LOWER: rd_mux = drive_w[b];
            K_SENSE:                   rd_mux = sense_w[b];
            K_EVENT:                   rd_mux = event_w[b];
            K_MSET, K_MCLR:            rd_mux = mask_w[b];
            default:                   rd_mux = level_w[b];
          endcase
        end
      end
    end else if (aligned && !bank_area && cfg_hit) begin
      mapped = 1'b1;
      rd_mux = cfg_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R12: a read of an unmapped location yields zero
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);
endmodule

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
  localparam int NB = 2;
  localparam int BW = 32;
  localparam int NP = NB * BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NB-1:0] irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_edge_bank #(.NBANKS(NB), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // bench model
  logic [31:0] m_drv [NB];
  logic [31:0] m_msk [NB];
  logic [31:0] m_evt [NB];
  logic        m_dir [NP];
  logic [1:0]  m_trg [NP];
  logic [NP-1:0] m_pins;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [11:0] a);
    logic [31:0] r;
    int b, w;
    r = '0;
    if (a[1:0] != 2'b00) return '0;
    if (a[11:8] == 4'h0) begin
      b = int'(a[4:2]);
      if (b >= NB) return '0;
      case (a[7:5])
        3'd0, 3'd2, 3'd3: r = m_drv[b];
        3'd1: r = m_pins[b*BW +: BW];
        3'd4: r = m_evt[b];
        3'd5, 3'd6: r = m_msk[b];
        default: for (int i = 0; i < BW; i++)
                   r[i] = m_dir[b*BW+i] ? m_pins[b*BW+i] : m_drv[b][i];
      endcase
    end else begin
      w = int'(a[11:2]) - 64;
      if (w >= 0 && w < NP) begin
        r[0] = m_dir[w];
        r[4:3] = m_trg[w];
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_oe();
    logic [63:0] v;
    v = '0;
    for (int p = 0; p < NP; p++) v[p] = ~m_dir[p];
    return v;
  endfunction

  function automatic logic [63:0] exp_irq();
    logic [63:0] v;
    v = '0;
    for (int b = 0; b < NB; b++) v[b] = |(m_evt[b] & ~m_msk[b]);
    return v;
  endfunction

  function automatic logic [NP-1:0] hits_for(logic [NP-1:0] oldv, logic [NP-1:0] newv);
    logic [NP-1:0] h;
    for (int p = 0; p < NP; p++) begin
      logic r, f;
      r = newv[p] & ~oldv[p];
      f = ~newv[p] & oldv[p];
      h[p] = (m_trg[p] == 2'd1 && r) || (m_trg[p] == 2'd2 && f) ||
             (m_trg[p] == 2'd3 && (r || f));
    end
    return h;
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    int b, w;
    if (a[1:0] != 2'b00) return;
    if (a[11:8] == 4'h0) begin
      b = int'(a[4:2]);
      if (b >= NB) return;
      case (a[7:5])
        3'd2: m_drv[b] = m_drv[b] | d;
        3'd3: m_drv[b] = m_drv[b] & ~d;
        3'd4: m_evt[b] = m_evt[b] & ~d;
        3'd5: m_msk[b] = m_msk[b] | d;
        3'd6: m_msk[b] = m_msk[b] & ~d;
        default: ;
      endcase
    end else begin
      w = int'(a[11:2]) - 64;
      if (w >= 0 && w < NP) begin
        m_dir[w] = d[0];
        m_trg[w] = d[4:3];
      end
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(string req, logic [11:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {32'h0, rdata}, {32'h0, exp_read(a)});
  endtask

  task automatic set_pins(logic [NP-1:0] v);
    logic [NP-1:0] h;
    @(negedge clk);
    pin_in = v;
    h = hits_for(m_pins, v);
    m_pins = v;
    for (int b = 0; b < NB; b++) m_evt[b] = m_evt[b] | h[b*BW +: BW];
    @(negedge clk);
  endtask

  task automatic chk_ports(string req);
    chk({req, " pin_out"}, pin_out, {m_drv[1], m_drv[0]});
    chk({req, " pin_oe"}, pin_oe, exp_oe());
    chk({req, " irq"}, {62'h0, irq}, exp_irq());
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int b = 0; b < NB; b++) begin
      m_drv[b] = '0; m_msk[b] = '1; m_evt[b] = '0;
    end
    for (int p = 0; p < NP; p++) begin
      m_dir[p] = 1'b1; m_trg[p] = 2'd0;
    end
    m_pins = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values
    chk_ports("R1");
    rd_chk("R1 mask", 12'h0A0);
    rd_chk("R1 mask b1", 12'h0A4);
    rd_chk("R1 event", 12'h080);
    rd_chk("R1 cfg", 12'h100);
    rd_chk("R1 cfg last", 12'h1FC);

    // R2 / R3: raise and lower
    wr(12'h040, 32'hF0F0_00FF);
    chk_ports("R2");
    wr(12'h044, 32'h8000_0001);
    chk_ports("R2 bank1");
    wr(12'h040, 32'h0000_0000);
    chk_ports("R2 zeros");
    wr(12'h060, 32'h3000_000F);
    chk_ports("R3");
    rd_chk("R11 drive", 12'h000);
    rd_chk("R11 raise addr", 12'h040);
    rd_chk("R11 lower addr", 12'h064);

    // R11: writes to drive and sense addresses ignored
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    chk_ports("R11 ignored");
    rd_chk("R11 drive after", 12'h000);

    // R4: direction
    wr(12'h100 + 4*3, 32'hFFFF_FFE6);  // dir 0, trig 0, junk elsewhere
    chk_ports("R4");
    rd_chk("R4 cfg", 12'h100 + 4*3);
    wr(12'h100 + 4*40, 32'h0);
    chk_ports("R4 bank1");

    // R10: level view
    set_pins(64'h0000_0100_0000_0009);
    rd_chk("R10 level", 12'h0E0);
    rd_chk("R10 level b1", 12'h0E4);
    rd_chk("R11 sense", 12'h020);

    // R5: event types
    wr(12'h100 + 4*5, 32'h09);   // rise
    wr(12'h100 + 4*6, 32'h11);   // fall
    wr(12'h100 + 4*7, 32'h19);   // both
    wr(12'h100 + 4*8, 32'h01);   // off
    set_pins(m_pins | 64'h1E0);
    rd_chk("R5 rise/both", 12'h080);
    set_pins(m_pins & ~64'h1E0);
    rd_chk("R5 fall/both", 12'h080);
    chk_ports("R8 masked");

    // R8 / R9: unmask shows pending
    wr(12'h0C0, 32'h0000_0080);
    chk_ports("R9 unmask");
    rd_chk("R7 mask", 12'h0C0);
    wr(12'h0A0, 32'h0000_0080);
    chk_ports("R7 remask");
    wr(12'h0C0, 32'hFFFF_FFFF);
    chk_ports("R9 all unmasked");

    // R6: acknowledge and coincident event
    wr(12'h080, 32'h0000_0020);
    chk_ports("R6 ack");
    rd_chk("R6 event", 12'h080);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h080; wdata = 32'hFFFF_FFFF;
    pin_in = m_pins | 64'h20;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(12'h080, 32'hFFFF_FFFF);
    begin
      logic [NP-1:0] h;
      h = hits_for(m_pins, m_pins | 64'h20);
      m_pins = m_pins | 64'h20;
      for (int b = 0; b < NB; b++) m_evt[b] = m_evt[b] | h[b*BW +: BW];
    end
    rd_chk("R6 coincident", 12'h080);
    chk_ports("R6 coincident");

    // R12: unmapped and unaligned
    rd_chk("R12 bank idx", 12'h00C);
    rd_chk("R12 cfg range", 12'h200);
    rd_chk("R12 unaligned", 12'h102);
    wr(12'h04C, 32'hFFFF_FFFF);
    wr(12'h042, 32'hFFFF_FFFF);
    chk_ports("R12 writes ignored");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op, b;
      logic [31:0] d;
      op = $urandom % 8;
      b  = $urandom % NB;
      d  = $urandom & $urandom;
      case (op)
        0: wr(12'(12'h040 + 4*b), d);
        1: wr(12'(12'h060 + 4*b), d);
        2: wr(12'(12'h080 + 4*b), d);
        3: wr(12'(12'h0A0 + 4*b), d & $urandom);
        4: wr(12'(12'h0C0 + 4*b), d);
        5: wr(12'(12'h100 + 4*($urandom % NP)), $urandom);
        6: set_pins(m_pins ^ {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom});
        default: rd_chk("R11 random read", 12'(($urandom % 8) * 32 + 4*b));
      endcase
      chk_ports("R9 random");
      if (it % 50 == 0) rd_chk("R5 random event", 12'(12'h080 + 4*b));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule